// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using a direct-mapped table of small saturating state machines. The fetch stage presents a PC on the lookup port and gets a taken / not-taken guess back in the same cycle, with no register on the path. When a branch resolves later in the pipeline, its PC and real outcome arrive on the update port under a valid strobe. The entry that PC maps to is trained at the next clock edge.

The table holds no address tags. The index is cut from the PC at word granularity, so two branches whose PCs share those index bits use and train one entry. That aliasing is accepted in exchange for storage. In the default mode each entry is a two-bit counter with hysteresis: states 2'b10 and 2'b11 guess taken, 2'b01 and 2'b00 guess not taken. A parameter switches every entry to a single bit that records the last outcome.

Top module: `branch_dir_predictor`

## Requirements
- R1: After a synchronous active-low reset, every entry guesses not taken. In two-bit mode the reset state is 2'b01 (weakly not taken). In one-bit mode it is 0.
- R2: The entry index is PC bits [11:2]. PCs that differ only in bits [1:0] or above bit 11 share one entry, and no tag check stops that sharing.
- R3: In two-bit mode an entry in a strong state (2'b11 or 2'b00) needs two wrong outcomes in a row before its guess flips. A taken outcome moves the counter up by one and a not-taken outcome moves it down by one.
- R4: In two-bit mode the counter saturates. A taken outcome leaves 2'b11 at 2'b11, and a not-taken outcome leaves 2'b00 at 2'b00.
- R5: The guess for the lookup PC is combinational: it reflects the table contents in the cycle the PC is applied.
- R6: When a lookup and an update hit the same entry in one cycle, the lookup returns the value from before the update. The trained value is visible from the next cycle on.
- R7: While the update valid strobe is low, no entry changes, whatever the update PC and outcome inputs carry.
- R8: In one-bit mode each entry stores the last outcome (1 = taken, 0 = not taken). A loop branch taken nine times and then not taken once is therefore mispredicted twice on every pass. In two-bit mode, once the counter is warmed up, the same pattern costs one misprediction per pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | PC of the fetched branch to predict |
| lk_taken | output | 1 | Guess for lk_pc: 1 = taken |
| upd_valid | input | 1 | Update strobe: train the entry of upd_pc at this edge |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch: 1 = taken |

## Verification
The assertions assume that reset is held low for at least one clock edge before it is released, so that every entry holds a known state. They also assume that the update inputs carry defined values in every cycle after reset, including cycles where the strobe is low. The bench keeps reset low for several edges and drives every input at the falling edge, never leaving one undriven. Random update PCs are confined to sixteen index values, with random upper and low bits, so that entries are hit repeatedly, reach saturation and alias with one another.

// File: rtl/bp_pkg.sv
// Shared encodings for the branch direction predictor.
// Assumes: two-bit entries use the four-state ladder below, where the
// most significant bit is the taken/not-taken guess.
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_NT_STRONG = 2'b00,
        CTR_NT_WEAK   = 2'b01,
        CTR_T_WEAK    = 2'b10,
        CTR_T_STRONG  = 2'b11
    } ctr2_e;

endpackage

// File: rtl/bp_index_slice.sv
// Cuts the table index out of a PC.
// Assumes: IDX_LSB + IDX_W <= PC_W and IDX_LSB >= 1; the bits outside
// the slice play no part in the index (no tag is kept).
module bp_index_slice #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 10,
    parameter int IDX_LSB = 2
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);

    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    // Bits dropped from the index on purpose.
    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:IDX_MSB+1], pc[IDX_LSB-1:0]};

    // Index slice.
    assign idx = pc[IDX_MSB:IDX_LSB];

endmodule

// File: rtl/bp_state_next.sv
// Next-state function for one table entry.
// Assumes: CNT_W is 1 in one-bit mode and 2 otherwise.
// One-bit mode stores the outcome as is; two-bit mode is a saturating
// up/down counter.
module bp_state_next #(
    parameter int ONE_BIT_MODE = 0,
    parameter int CNT_W        = 2
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             taken,
    output logic [CNT_W-1:0] nxt
);
    import bp_pkg::*;

    if (ONE_BIT_MODE != 0) begin : g_one_bit
        // Record the last outcome; a wrong guess thus inverts the bit.
        assign nxt = CNT_W'(taken);
    end else begin : g_two_bit
        ctr2_e cur_e;
        ctr2_e nxt_e;
        assign cur_e = ctr2_e'(cur[1:0]);

        // Saturating step toward the observed outcome.
        always_comb begin
            nxt_e = cur_e;
            unique case (cur_e)
                CTR_NT_STRONG: nxt_e = taken ? CTR_NT_WEAK  : CTR_NT_STRONG;
                CTR_NT_WEAK:   nxt_e = taken ? CTR_T_WEAK   : CTR_NT_STRONG;
                CTR_T_WEAK:    nxt_e = taken ? CTR_T_STRONG : CTR_NT_WEAK;
                CTR_T_STRONG:  nxt_e = taken ? CTR_T_STRONG : CTR_T_WEAK;
                default:       nxt_e = CTR_NT_WEAK;
            endcase
        end

        assign nxt = CNT_W'(nxt_e);
    end

endmodule

// File: rtl/bp_hist_table.sv
// Direct-mapped state storage with two asynchronous read ports and one
// synchronous write port.
// Assumes: reads return the contents from before any write at the same
// edge; a synchronous active-low reset loads RST_VAL into every entry.
module bp_hist_table #(
    parameter int              IDX_W   = 10,
    parameter int              CNT_W   = 2,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [CNT_W-1:0] rd_a_state,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [CNT_W-1:0] rd_b_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_state
);

    localparam int DEPTH = 1 << IDX_W;

    logic [CNT_W-1:0] mem_q [DEPTH];

    // Reset every entry, otherwise write the trained entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= RST_VAL;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_state;
        end
    end

    // Combinational read ports.
    assign rd_a_state = mem_q[rd_a_idx];
    assign rd_b_state = mem_q[rd_b_idx];

endmodule

// File: rtl/branch_dir_predictor.sv
// Untagged direct-mapped branch direction predictor.
// Assumes: lookup is answered combinationally from the stored state;
// training reads the entry at the update index, steps it and writes it back at
// the next edge when upd_valid is high. Aliasing between branches with equal
// index bits is accepted.
module branch_dir_predictor #(
    parameter int PC_W         = 32,
    parameter int IDX_W        = 10,
    parameter int IDX_LSB      = 2,
    parameter int ONE_BIT_MODE = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int               CNT_W   = (ONE_BIT_MODE != 0) ? 1 : 2;
    localparam logic [CNT_W-1:0] RST_VAL = (ONE_BIT_MODE != 0) ? '0 : CNT_W'(1);

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] upd_idx;
    logic [CNT_W-1:0] lk_state;
    logic [CNT_W-1:0] up_state;
    logic [CNT_W-1:0] up_next;

    // Index for the lookup port.
    bp_index_slice #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_lk_slice (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    // Index for the update port.
    bp_index_slice #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_up_slice (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    // Entry storage.
    bp_hist_table #(.IDX_W(IDX_W), .CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (lk_idx),
        .rd_a_state (lk_state),
        .rd_b_idx   (upd_idx),
        .rd_b_state (up_state),
        .wr_en      (upd_valid),
        .wr_idx     (upd_idx),
        .wr_state   (up_next)
    );

    // Training step for the entry being updated.
    bp_state_next #(.ONE_BIT_MODE(ONE_BIT_MODE), .CNT_W(CNT_W)) u_step (
        .cur   (up_state),
        .taken (upd_taken),
        .nxt   (up_next)
    );

    // Guess is the top bit of the looked-up entry.
    assign lk_taken = lk_state[CNT_W-1];

endmodule

// File: rtl/bp_pred_chk.sv
// Property checker for branch_dir_predictor, bound to every instance.
// Assumes: reset is low for at least one edge before release.
module bp_pred_chk #(
    parameter int IDX_W        = 10,
    parameter int CNT_W        = 2,
    parameter int ONE_BIT_MODE = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_taken,
    input logic             upd_valid,
    input logic             upd_taken,
    input logic [IDX_W-1:0] lk_idx,
    input logic [IDX_W-1:0] upd_idx,
    input logic [CNT_W-1:0] up_state
);

    localparam logic [CNT_W-1:0] MAXV = '1;

    function automatic logic [CNT_W-1:0] step_of(logic [CNT_W-1:0] s, logic t);
        if (ONE_BIT_MODE != 0) return CNT_W'(t);
        if (t)  return (s == MAXV) ? s : s + CNT_W'(1);
        return (s == '0) ? s : s - CNT_W'(1);
    endfunction

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_taken);

    // R3
    train_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (upd_idx != $past(upd_idx)) ||
                      (up_state == step_of($past(up_state), $past(upd_taken))));

    // R4
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && up_state == MAXV) |=>
            (upd_idx != $past(upd_idx)) || (up_state == MAXV));

    // R4
    floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && up_state == '0) |=>
            (upd_idx != $past(upd_idx)) || (up_state == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> (upd_idx != $past(upd_idx)) || $stable(up_state));

    // R6
    old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && lk_idx == upd_idx) |-> (lk_taken == up_state[CNT_W-1]));

endmodule

bind branch_dir_predictor bp_pred_chk #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .ONE_BIT_MODE(ONE_BIT_MODE)
) u_pred_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_taken  (lk_taken),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .lk_idx    (lk_idx),
    .upd_idx   (upd_idx),
    .up_state  (up_state)
);

// File: tb/tb_branch_dir_predictor.sv
module tb_branch_dir_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        lk_taken;
    logic        lk_taken_1b;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [1:0] m2 [1024];
    logic       m1 [1024];
    logic       got2, got1;

    always #2 clk = ~clk;   // 250 MHz

    branch_dir_predictor #(.ONE_BIT_MODE(0)) dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

    branch_dir_predictor #(.ONE_BIT_MODE(1)) dut_1b (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken_1b),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

    function automatic int idx_of(logic [31:0] pc);
        return int'(pc[11:2]);
    endfunction

    function automatic logic [1:0] ref_step2(logic [1:0] s, logic t);
        if (t) return (s == 2'b11) ? s : s + 2'b01;
        return (s == 2'b00) ? s : s - 2'b01;
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Drive one cycle, check both guesses before the edge, then train models.
    task automatic apply(string req, logic [31:0] lpc, logic uv,
                         logic [31:0] upc, logic ut);
        @(negedge clk);
        lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #1;
        got2 = lk_taken;
        got1 = lk_taken_1b;
        check(req, "two-bit guess", got2, m2[idx_of(lpc)][1]);
        check(req, "one-bit guess", got1, m1[idx_of(lpc)]);
        @(posedge clk);
        if (uv) begin
            m2[idx_of(upc)] = ref_step2(m2[idx_of(upc)], ut);
            m1[idx_of(upc)] = ut;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int miss2, miss1;
        logic [31:0] lp, up;
        for (int i = 0; i < 1024; i++) begin
            m2[i] = 2'b01;
            m1[i] = 1'b0;
        end
        void'($urandom(32'd4611));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: every entry guesses not taken after reset (sweep, no updates).
        for (int i = 0; i < 1024; i += 37)
            apply("R1", 32'(i) << 2, 1'b0, '0, 1'b0);

        // R5 and R6: same-cycle lookup/update returns the old guess.
        apply("R6", 32'h0000_0080, 1'b1, 32'h0000_0080, 1'b1);
        apply("R5", 32'h0000_0080, 1'b0, '0, 1'b0);

        // R2: bits above 11 and bits [1:0] do not change the entry.
        apply("R2", 32'h0000_0100, 1'b1, 32'hABC0_0102, 1'b1);
        apply("R2", 32'h5550_0103, 1'b0, '0, 1'b0);

        // R3 and R4: saturate high, then two wrong outcomes to flip.
        for (int k = 0; k < 4; k++)
            apply("R4", 32'h0000_0200, 1'b1, 32'h0000_0200, 1'b1);
        apply("R3", 32'h0000_0200, 1'b1, 32'h0000_0200, 1'b0);
        apply("R3", 32'h0000_0200, 1'b1, 32'h0000_0200, 1'b0);
        apply("R3", 32'h0000_0200, 1'b0, '0, 1'b0);
        for (int k = 0; k < 4; k++)
            apply("R4", 32'h0000_0200, 1'b1, 32'h0000_0200, 1'b0);
        apply("R4", 32'h0000_0200, 1'b1, 32'h0000_0200, 1'b1);
        apply("R4", 32'h0000_0200, 1'b0, '0, 1'b0);

        // R7: strobe low with taken outcomes on an untouched entry.
        for (int k = 0; k < 5; k++)
            apply("R7", 32'h0000_0400, 1'b0, 32'h0000_0400, 1'b1);
        apply("R7", 32'h0000_0400, 1'b0, '0, 1'b0);

        // R8: three passes of nine taken then one not taken.
        for (int p = 0; p < 3; p++) begin
            miss2 = 0; miss1 = 0;
            for (int it = 0; it < 10; it++) begin
                apply("R8", 32'h0000_0800, 1'b1, 32'h0000_0800, it < 9);
                if (got2 != (it < 9)) miss2++;
                if (got1 != (it < 9)) miss1++;
            end
            n_vec++;
            if (miss1 != 2) begin
                n_bad++;
                $display("FAIL R8 one-bit misses pass %0d: got %0d expected 2", p, miss1);
            end
            if (p > 0) begin
                n_vec++;
                if (miss2 != 1) begin
                    n_bad++;
                    $display("FAIL R8 two-bit misses pass %0d: got %0d expected 1", p, miss2);
                end
            end
        end

        // Random traffic on sixteen aliased indices (R2, R3, R4, R6, R7).
        for (int k = 0; k < 3000; k++) begin
            lp = $urandom & 32'hFFFF_F03F;
            up = (k % 5 == 0) ? lp : ($urandom & 32'hFFFF_F03F);
            apply("R3", lp, ($urandom % 4) != 0, up, $urandom % 2);
        end

        finish_run();
    end

endmodule